// File: doc/BRIEF.md
# Manchester bit-check receive decoder

This block sits behind a demodulator and turns an oversampled, Manchester-coded data line into decoded bits. Every time the line changes level it measures how many clock cycles the previous level lasted. It sorts that interval as a half-bit period (short), a full-bit period (long) or invalid, using four limit values given in clock cycles. While hunting, it waits for a run of short intervals, which a preburst of identical bits produces. It then looks for the first long interval, which can only occur where the start bit differs from the preburst value.

Once the start bit has been found, the decoder keeps track of whether the last edge was at a bit centre or at a bit boundary. Each centre edge yields one decoded bit, and the direction of that edge sets the bit value. A bad interval, a line that stays stuck past the long maximum, or a long interval that begins at a boundary raises a one-cycle bit-error pulse. That last case means the bit centre had no edge. After a bit error the decoder goes back to hunting for a preburst. Dropping the enable returns it to idle at any time.

Top module: `mbc_rx`

## Requirements
- R1: After reset, and in every cycle following one with `en` low, `bit_vld`, `start_det` and `bit_err` are 0. A frame sent while `en` is low produces no pulses.
- R2: While hunting, the decoder needs at least PRE_MIN (default 4) consecutive short intervals followed by a long interval. It then pulses `start_det` and `bit_vld` together. `bit_val` carries the start bit, which is the inverse of the preburst bit value.
- R3: A bit is encoded as two half periods: 1 is low then high, and 0 is high then low. A rising centre edge decodes to `bit_val`=1 and a falling one to 0. Each decoded bit gives exactly one `bit_vld` pulse.
- R4: An interval is the number of clock cycles the synchronised line holds one level. It counts as short when `s_min` <= interval <= `s_max`, and as long when `l_min` <= interval <= `l_max`. In data mode, an interval that is neither short nor long raises `bit_err`.
- R5: The interval counter saturates at 255. In data mode, once the counter exceeds `l_max` without an edge (a stuck line), `bit_err` is raised.
- R6: In data mode, a long interval that starts at a bit boundary is a logical error. It raises `bit_err` and no bit is emitted.
- R7: After `bit_err` the decoder hunts for a new preburst. A following frame decodes without `en` being toggled.
- R8: The four limits are run-time inputs. A frame whose timing fits one set of limits decodes correctly under that set.
- R9: Bits are emitted in the order received: first the start bit, then the data bits.
- R10: No `bit_err` is raised while hunting, whatever intervals the line shows, including a saturated counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Decoder enable; low forces idle |
| rx_in | input | 1 | Demodulated data line (asynchronous) |
| s_min | input | 8 | Half-period minimum, cycles |
| s_max | input | 8 | Half-period maximum, cycles |
| l_min | input | 8 | Full-period minimum, cycles |
| l_max | input | 8 | Full-period maximum, cycles |
| bit_val | output | 1 | Decoded bit value, valid with bit_vld |
| bit_vld | output | 1 | One-cycle strobe per decoded bit |
| start_det | output | 1 | One-cycle pulse when the start bit is found |
| bit_err | output | 1 | One-cycle pulse on a timing or logical error |

## Verification
The hardest case to reach from the ports is the logical error. There, every interval is inside its window, yet a long interval follows a boundary edge, so a bit centre has no edge. This case exists only in data mode with the boundary phase known. The bench therefore sends a valid preburst and start bit, then drives raw line segments: one half period to produce the boundary edge, then a double period. The timing-error and stuck-line cases are reached the same way, by driving segments of chosen length directly after a correctly detected start bit.

// File: rtl/mbc_pkg.sv
package mbc_pkg;
  localparam int CNT_W = 8;

  typedef enum logic [1:0] {IV_BAD, IV_SHORT, IV_LONG} iv_cls_e;
  typedef enum logic [1:0] {ST_IDLE, ST_HUNT, ST_DATA} rx_st_e;
endpackage

// File: rtl/mbc_sync_edge.sv
module mbc_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic lvl,
  output logic edge_seen,
  output logic rise
);
  logic [STAGES-1:0] sh;
  logic              lvl_d;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh    <= '0;
      lvl_d <= 1'b0;
    end else begin
      sh    <= {sh[STAGES-2:0], din};
      lvl_d <= sh[STAGES-1];
    end
  end

  assign lvl       = sh[STAGES-1];
  assign edge_seen = lvl ^ lvl_d;
  assign rise      = edge_seen & lvl;
endmodule

// File: rtl/mbc_interval.sv
module mbc_interval #(
  parameter int CW = mbc_pkg::CNT_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          edge_seen,
  output logic [CW-1:0] cnt
);
  localparam logic [CW-1:0] TOP = '1;

  always_ff @(posedge clk) begin
    if (!rst_n)         cnt <= '0;
    else if (edge_seen) cnt <= CW'(1);
    else if (cnt != TOP) cnt <= cnt + 1'b1;
  end

  // R5
  sat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == TOP && !edge_seen) |=> cnt == TOP);
endmodule

// File: rtl/mbc_rx.sv
module mbc_rx #(
  parameter int CW          = mbc_pkg::CNT_W,
  parameter int PRE_MIN     = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          rx_in,
  input  logic [CW-1:0] s_min,
  input  logic [CW-1:0] s_max,
  input  logic [CW-1:0] l_min,
  input  logic [CW-1:0] l_max,
  output logic          bit_val,
  output logic          bit_vld,
  output logic          start_det,
  output logic          bit_err
);
  import mbc_pkg::*;

  localparam int            PW     = $clog2(PRE_MIN + 1);
  localparam logic [PW-1:0] PRE_OK = PW'(PRE_MIN);
  localparam logic [CW-1:0] CTOP   = '1;

  function automatic logic in_win(input logic [CW-1:0] v, lo, hi);
    return (v >= lo) && (v <= hi);
  endfunction

  function automatic iv_cls_e classify(input logic [CW-1:0] v, smn, smx, lmn, lmx);
    if (in_win(v, smn, smx))      return IV_SHORT;
    else if (in_win(v, lmn, lmx)) return IV_LONG;
    else                          return IV_BAD;
  endfunction

  function automatic logic overdue(input logic [CW-1:0] v, lmx);
    return (v > lmx) || (v == CTOP);
  endfunction

  logic          lvl, tog, rise;
  logic [CW-1:0] cnt;
  iv_cls_e       cls;
  logic          late;

  mbc_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(rx_in),
    .lvl(lvl), .edge_seen(tog), .rise(rise)
  );

  mbc_interval #(.CW(CW)) u_iv (
    .clk(clk), .rst_n(rst_n), .edge_seen(tog), .cnt(cnt)
  );

  assign cls  = classify(cnt, s_min, s_max, l_min, l_max);
  assign late = overdue(cnt, l_max);

  rx_st_e        st, st_n;
  logic          at_mid, mid_n;
  logic [PW-1:0] pre_cnt, pre_n;
  logic          vld_n, val_n, start_n, err_n;

  always_comb begin
    st_n    = st;
    mid_n   = at_mid;
    pre_n   = pre_cnt;
    vld_n   = 1'b0;
    val_n   = 1'b0;
    start_n = 1'b0;
    err_n   = 1'b0;
    if (!en) begin
      st_n = ST_IDLE;
    end else begin
      case (st)
        ST_IDLE: begin
          st_n  = ST_HUNT;
          pre_n = '0;
        end
        ST_HUNT: if (tog) begin
          if (cls == IV_SHORT) begin
            if (pre_cnt != PRE_OK) pre_n = pre_cnt + 1'b1;
          end else if (cls == IV_LONG && pre_cnt == PRE_OK) begin
            start_n = 1'b1;
            vld_n   = 1'b1;
            val_n   = rise;
            mid_n   = 1'b1;
            st_n    = ST_DATA;
          end else begin
            pre_n = '0;
          end
        end
        ST_DATA: if (tog) begin
          if (cls == IV_BAD) begin
            err_n = 1'b1;
          end else if (at_mid) begin
            if (cls == IV_SHORT) mid_n = 1'b0;
            else begin
              vld_n = 1'b1;
              val_n = rise;
            end
          end else if (cls == IV_SHORT) begin
            vld_n = 1'b1;
            val_n = rise;
            mid_n = 1'b1;
          end else begin
            err_n = 1'b1;
          end
        end else if (late) begin
          err_n = 1'b1;
        end
        default: st_n = ST_IDLE;
      endcase
    end
    if (err_n) begin
      st_n  = ST_HUNT;
      pre_n = '0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      at_mid    <= 1'b0;
      pre_cnt   <= '0;
      bit_vld   <= 1'b0;
      bit_val   <= 1'b0;
      start_det <= 1'b0;
      bit_err   <= 1'b0;
    end else begin
      st        <= st_n;
      at_mid    <= mid_n;
      pre_cnt   <= pre_n;
      bit_vld   <= vld_n;
      bit_val   <= val_n;
      start_det <= start_n;
      bit_err   <= err_n;
    end
  end

  // R1
  quiet_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !(bit_vld || start_det || bit_err));
  // R2
  start_has_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |-> bit_vld && st == ST_DATA);
  // R3
  vld_on_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bit_vld |-> $past(tog));
  // R6
  err_no_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bit_err |-> !bit_vld);
  // R7
  err_to_hunt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bit_err |-> st == ST_HUNT);
  // R10
  hunt_no_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bit_err |-> $past(st) == ST_DATA);
endmodule

// File: tb/sim_mbc_rx.sv
module sim_mbc_rx;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en = 1'b0;
  logic       rx = 1'b0;
  logic [7:0] s_min = 8'd6, s_max = 8'd10, l_min = 8'd14, l_max = 8'd18;
  logic       bit_val, bit_vld, start_det, bit_err;

  int total = 0;
  int bad   = 0;
  int nbits = 0, nstart = 0, nerr = 0;
  logic [31:0] rec_sh = '0;

  always #5 clk = ~clk;

  mbc_rx u0 (
    .clk(clk), .rst_n(rst_n), .en(en), .rx_in(rx),
    .s_min(s_min), .s_max(s_max), .l_min(l_min), .l_max(l_max),
    .bit_val(bit_val), .bit_vld(bit_vld), .start_det(start_det), .bit_err(bit_err)
  );

  always @(negedge clk) begin
    if (bit_vld)   begin rec_sh = {rec_sh[30:0], bit_val}; nbits = nbits + 1; end
    if (start_det) nstart = nstart + 1;
    if (bit_err)   nerr = nerr + 1;
  end

  // {preburst bit, data byte, half period in cycles}
  localparam logic [16:0] VEC [6] = '{
    {1'b0, 8'hA5, 8'd8}, {1'b1, 8'h5A, 8'd8}, {1'b0, 8'h00, 8'd7},
    {1'b1, 8'hFF, 8'd9}, {1'b1, 8'h3C, 8'd7}, {1'b0, 8'hFE, 8'd9}
  };

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic seg(input logic lv, input int n);
    rx = lv;
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bit(input logic b, input int h);
    if (b) begin seg(1'b0, h); seg(1'b1, h); end
    else   begin seg(1'b1, h); seg(1'b0, h); end
  endtask

  task automatic preamble(input logic pre, input int h);
    seg(1'b0, 40);
    for (int i = 0; i < 8; i++) send_bit(pre, h);
    send_bit(~pre, h);
  endtask

  task automatic frame(input logic pre, input logic [7:0] d, input int h);
    preamble(pre, h);
    for (int i = 7; i >= 0; i--) send_bit(d[i], h);
  endtask

  task automatic frame_check(input logic pre, input logic [7:0] d, input int h, input string tg);
    int b0, s0, e0;
    b0 = nbits; s0 = nstart; e0 = nerr;
    en = 1'b1;
    frame(pre, d, h);
    en = 1'b0;
    repeat (6) @(negedge clk);
    chk(nstart - s0 == 1, {tg, " start count"}, nstart - s0, 1);
    chk(nbits - b0 == 9, {tg, " bit count"}, nbits - b0, 9);
    chk(rec_sh[8:0] == {~pre, d}, {tg, " bit values"}, int'(rec_sh[8:0]), int'({~pre, d}));
    chk(nerr - e0 == 0, {tg, " no error"}, nerr - e0, 0);
  endtask

  task automatic err_case(input int kind, input string tg);
    int b0, s0, e0;
    b0 = nbits; s0 = nstart; e0 = nerr;
    en = 1'b1;
    preamble(1'b0, 8);
    case (kind)
      0: begin seg(1'b0, 4);  seg(1'b1, 8); end
      1: begin seg(1'b0, 12); seg(1'b1, 8); end
      2: seg(1'b1, 40);
      default: begin seg(1'b0, 16); seg(1'b1, 8); end
    endcase
    repeat (6) @(negedge clk);
    chk(nerr - e0 == 1, {tg, " error pulse"}, nerr - e0, 1);
    chk(nbits - b0 == 1, {tg, " only start bit"}, nbits - b0, 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog R1..all act=hung exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int b0, s0, e0;
    repeat (4) @(negedge clk);
    chk(!bit_vld && !start_det && !bit_err, "R1 outputs in reset", int'({bit_vld, start_det, bit_err}), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(!bit_vld && !start_det && !bit_err, "R1 outputs after reset", int'({bit_vld, start_det, bit_err}), 0);

    // table walk: R2 R3 R4 R9
    foreach (VEC[k])
      frame_check(VEC[k][16], VEC[k][15:8], int'(VEC[k][7:0]), "R2 R3 R9 table");

    // R1 frame while disabled
    b0 = nbits; s0 = nstart; e0 = nerr;
    en = 1'b0;
    frame(1'b0, 8'h96, 8);
    repeat (6) @(negedge clk);
    chk(nbits == b0 && nstart == s0 && nerr == e0, "R1 disabled frame", nbits - b0, 0);

    // R8 other limits
    s_min = 8'd18; s_max = 8'd22; l_min = 8'd38; l_max = 8'd42;
    frame_check(1'b0, 8'hC3, 20, "R8 wide limits");
    s_min = 8'd6; s_max = 8'd10; l_min = 8'd14; l_max = 8'd18;

    err_case(0, "R4 short below min");
    en = 1'b0; seg(1'b0, 4);
    err_case(1, "R4 gap between windows");
    en = 1'b0; seg(1'b0, 4);
    err_case(2, "R5 stuck line");
    en = 1'b0; seg(1'b0, 4);
    err_case(3, "R6 missing centre edge");

    // R7 recovery without toggling en
    b0 = nbits; s0 = nstart; e0 = nerr;
    frame(1'b1, 8'h69, 8);
    en = 1'b0;
    repeat (6) @(negedge clk);
    chk(nstart - s0 == 1 && nbits - b0 == 9, "R7 recovery count", nbits - b0, 9);
    chk(rec_sh[8:0] == 9'h069, "R7 recovery bits", int'(rec_sh[8:0]), 9'h069);

    // R10 garbage and saturation while hunting
    e0 = nerr; s0 = nstart;
    en = 1'b1;
    seg(1'b1, 3); seg(1'b0, 30); seg(1'b1, 5); seg(1'b0, 16); seg(1'b1, 300);
    chk(nerr == e0, "R10 no error in hunt", nerr - e0, 0);
    chk(nstart == s0, "R10 no false start", nstart - s0, 0);
    en = 1'b0;
    seg(1'b0, 4);
    frame_check(1'b0, 8'h5C, 8, "R5 after saturation");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule